// File: doc/BRIEF.md
# Segmented Piecewise-Linear Gamma Unit

This block maps a 12-bit colour component through a gamma curve made of 64 straight-line pieces. The pieces are not equal in width. The lowest sixteen input codes each get a piece of their own. Above them the pieces come in sectors of four, and each sector's piece width is double the previous one (4, 8, 16, 32, 64). All codes from 512 upward are split into 28 pieces of 128 codes each. Dense pieces sit where a gamma curve bends sharply, and coarse pieces sit where it is nearly straight.

Each piece is described by one coefficient word, written through a simple indexed write port. The word holds a start value and a slope in 1/256 units. Pixels arrive with a valid strobe and pass through two register stages. The first stage finds the piece from the position of the input's leading one and reads that piece's coefficients. The second stage forms the start value plus the scaled offset and saturates the result to 12 bits. One curve serves all three colour channels, so a single coefficient set drives every instance.

Top module: `gamma_pwl`

## Requirements
- R1: While reset is asserted, and after reset until the first valid output, out_valid is 0 and out_pix is 0. All 64 coefficient entries reset to zero, so every pixel maps to 0 until coefficients are written.
- R2: out_valid in any cycle equals in_valid two rising clock edges earlier. Each accepted pixel yields exactly one output, and outputs come in input order.
- R3: Input codes 0 to 15 each use the entry whose index equals the code, with an offset of zero. The output is therefore that entry's start value.
- R4: Codes 16 to 511 use entries 16 to 35. Sector s (1 to 5) begins at code 8·2^s, holds four pieces each 2·2^s codes wide, and uses entries 16+4(s−1) to 19+4(s−1) in ascending code order.
- R5: Codes 512 to 4095 use entries 36 to 63. The entry is 36 + (x−512)/128, and that piece begins at 512 + 128·((x−512)/128).
- R6: In a coefficient word, bits 27:16 are the slope and bits 11:0 are the start value. Bits 31:28 and 15:12 have no effect on the output.
- R7: The output is start + floor((x − piece_start) × slope / 256), where piece_start is the lowest code of the piece that holds x.
- R8: Whenever the value of R7 exceeds 4095, the output is 4095.
- R9: A coefficient write takes effect at the clock edge that samples it. A pixel sampled at that same edge still uses the previous word. Pixels sampled at later edges use the new word, and pixels already past the first stage are not affected.
- R10: While out_valid is 0, out_pix keeps the last value it held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 6 | Coefficient entry index, 0 to 63 |
| cfg_data | input | 32 | Coefficient word: slope in 27:16, start in 11:0 |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 12 | Input pixel component |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 12 | Gamma-corrected pixel component |

## Verification
Every one of the 4096 input codes is streamed back-to-back under three curves. An identity curve (start equal to the piece start, slope 256) returns each code unchanged, so any error in piece boundaries or offsets shows up directly. A pseudo-random set of starts and slopes gives each entry a distinct signature, so reading the wrong entry or taking the wrong offset width changes the result. A steep curve with high starts drives most codes into saturation and separates correct clamping from wrap-around. Further tests cover words with junk in the unused bits, gaps in the valid strobe, and writes made while pixels stream.

// File: rtl/gamma_pwl.sv
module gamma_pwl #(
  parameter int PIX_W     = 12,
  parameter int FRAC_W    = 8,
  parameter int NSEG      = 64,
  parameter int WORD_W    = 32,
  parameter int SLOPE_LSB = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NSEG)-1:0]  cfg_idx,
  input  logic [WORD_W-1:0]        cfg_data,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_pix,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_pix
);

  localparam int IDX_W = $clog2(NSEG);
  localparam int PRD_W = 2 * PIX_W;
  localparam int SUM_W = PRD_W - FRAC_W + 1;

  logic [PIX_W-1:0] slope_mem [NSEG];
  logic [PIX_W-1:0] start_mem [NSEG];

  logic [IDX_W-1:0] seg_idx;
  logic [PIX_W-1:0] seg_off;

  logic             v1;
  logic [PIX_W-1:0] off1, slope1, start1;

  logic [PRD_W-1:0] prod;
  logic [SUM_W-1:0] sum;
  logic [PIX_W-1:0] sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        slope_mem[i] <= '0;
        start_mem[i] <= '0;
      end
    end else if (cfg_we) begin
      slope_mem[cfg_idx] <= cfg_data[SLOPE_LSB +: PIX_W];
      start_mem[cfg_idx] <= cfg_data[PIX_W-1:0];
    end
  end

  always_comb begin
    seg_idx = in_pix[IDX_W-1:0];
    seg_off = '0;
    if (in_pix >= PIX_W'(512)) begin
      seg_idx = IDX_W'(32) + IDX_W'(in_pix >> 7);
      seg_off = in_pix & PIX_W'(127);
    end else begin
      for (int p = 4; p <= 8; p++) begin
        if (in_pix[p]) begin
          seg_idx = IDX_W'(4 * p) + IDX_W'((in_pix >> (p - 2)) & PIX_W'(3));
          seg_off = in_pix & PIX_W'((1 << (p - 2)) - 1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      off1   <= '0;
      slope1 <= '0;
      start1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        off1   <= seg_off;
        slope1 <= slope_mem[seg_idx];
        start1 <= start_mem[seg_idx];
      end
    end
  end

  assign prod = PRD_W'(off1) * PRD_W'(slope1);
  assign sum  = SUM_W'(start1) + SUM_W'(prod >> FRAC_W);
  assign sat  = (|sum[SUM_W-1:PIX_W]) ? {PIX_W{1'b1}} : sum[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_pix <= sat;
    end
  end

  assert_latency_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_latency_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_small_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pix < PIX_W'(16)) |=> (off1 == '0));
  assert_word_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (slope_mem[$past(cfg_idx)] == $past(cfg_data[SLOPE_LSB +: PIX_W]) &&
                start_mem[$past(cfg_idx)] == $past(cfg_data[PIX_W-1:0])));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> (out_pix >= $past(start1)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(out_pix));

endmodule

// File: tb/gamma_pwl_bench.sv
module gamma_pwl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [11:0] in_pix = '0;
  logic        out_valid;
  logic [11:0] out_pix;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mword [64];
  logic        e1v = 1'b0, e2v = 1'b0;
  int          e1p = 0, e2p = 0, held = 0;

  gamma_pwl u_gamma_pwl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void piece(input int x, output int idx, output int base);
    if (x < 16) begin
      idx = x; base = x;
    end else if (x >= 512) begin
      idx = 36 + (x - 512) / 128; base = 512 + 128 * ((x - 512) / 128);
    end else begin
      idx = 0; base = 0;
      for (int s = 1; s <= 5; s++) begin
        int lo = 8 << s;
        int w  = 2 << s;
        if (x >= lo && x < 2 * lo) begin
          idx = 16 + 4 * (s - 1) + (x - lo) / w;
          base = lo + w * ((x - lo) / w);
        end
      end
    end
  endfunction

  function automatic int model(input int x);
    int idx, base, st, sl, r;
    piece(x, idx, base);
    st = int'(mword[idx] & 32'hfff);
    sl = int'((mword[idx] >> 16) & 32'hfff);
    r = st + ((x - base) * sl) / 256;
    return (r > 4095) ? 4095 : r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e1v <= 1'b0; e2v <= 1'b0;
      for (int i = 0; i < 64; i++) mword[i] = '0;
    end else begin
      e2v <= e1v; e2p <= e1p;
      e1v <= in_valid;
      if (in_valid) e1p <= model(int'(in_pix));
      if (cfg_we) mword[cfg_idx] = cfg_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == e2v, "R2 valid", int'(out_valid), int'(e2v));
      if (e2v) begin
        chk(int'(out_pix) == e2p, "R7 value", int'(out_pix), e2p);
        held = e2p;
      end else begin
        chk(int'(out_pix) == held, "R10 hold", int'(out_pix), held);
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] w);
    cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sweep(input bit gaps);
    for (int x = 0; x < 4096; x++) begin
      in_valid = 1'b1; in_pix = 12'(x);
      @(negedge clk);
      if (gaps && (x % 7 == 3)) begin
        in_valid = 1'b0; in_pix = 12'hABC;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lcg;
    int idx, base;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(out_pix == 12'd0, "R1 reset pix", int'(out_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zeroed coefficients give 0 everywhere
    for (int x = 0; x < 4096; x += 97) begin
      in_valid = 1'b1; in_pix = 12'(x); @(negedge clk);
    end
    in_valid = 1'b0; repeat (3) @(negedge clk);
    chk(out_pix == 12'd0, "R1 zero curve", int'(out_pix), 0);

    // R3 R4 R5: identity curve, junk in unused bits exercises R6
    for (int i = 0; i < 64; i++) begin
      if (i < 16) base = i;
      else if (i < 36) base = (8 << ((i - 16) / 4 + 1)) + (2 << ((i - 16) / 4 + 1)) * ((i - 16) % 4);
      else base = 512 + 128 * (i - 36);
      wr(i, 32'hF000F000 | (32'd256 << 16) | 32'(base));
    end
    sweep(1'b0);
    in_valid = 1'b1; in_pix = 12'd300; @(negedge clk);
    in_valid = 1'b0; repeat (2) @(negedge clk);
    chk(out_pix == 12'd300, "R4 R6 identity", int'(out_pix), 300);
    piece(4095, idx, base);
    chk(idx == 63, "R5 top entry", idx, 63);

    // pseudo-random curve with valid gaps
    lcg = 12345;
    for (int i = 0; i < 64; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      wr(i, 32'(lcg));
    end
    sweep(1'b1);

    // R8: steep curve saturates
    for (int i = 0; i < 64; i++) wr(i, (32'd4095 << 16) | 32'd4000);
    sweep(1'b0);
    in_valid = 1'b1; in_pix = 12'd1000; @(negedge clk);
    in_valid = 1'b0; repeat (2) @(negedge clk);
    chk(out_pix == 12'd4095, "R8 clamp", int'(out_pix), 4095);

    // R9: writes concurrent with streaming on code 5 (entry 5)
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b1; in_pix = 12'd5;
      if (k == 2) begin cfg_we = 1'b1; cfg_idx = 6'd5; cfg_data = 32'd111; end
      else if (k == 4) begin cfg_we = 1'b1; cfg_idx = 6'd5; cfg_data = 32'd222; end
      else cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_pix == 12'd222, "R9 last write used", int'(out_pix), 222);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule